// File: doc/BRIEF.md
# Windowed PCI-to-DMA Address Translator

This block turns an address seen on a PCI bus into a system memory (DMA) address. Software sets up four translation windows through a 64-bit register port. Each window has three registers: a base that holds the enable and mode flags, a size mask, and a translated base. When a bus address arrives, the block compares it against every window at once. The lowest-numbered enabled window that matches handles the request. If no window matches, the request is reported as a miss.

A window works in one of two modes. In direct mode the output is built from the translated base and a range of bus-address bits that the mask selects. In scatter-gather mode the block forms the address of a page-table entry and issues one 64-bit read on a simple memory request/response interface. It then builds the page address from the entry it gets back. While that fetch is outstanding, the block holds off new requests. Every result is cut to 34 bits.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset every window register reads as zero and every window is disabled. A legal write to one of the twelve window registers is read back unchanged as a 64-bit value.
- R2: The register index is the offset shifted right by 6, so offset bits 5:0 are ignored. The register map is:
    - Index 0 to 3: window bases.
    - Index 4 to 7: window masks.
    - Index 8 to 11: translated bases.
    - Index 12: invalidate register.
  Any other index sets csr_err, has no effect on any register and reads zero. Each access gets csr_rsp_valid one cycle after it is presented.
- R3: Only accesses with csr_size equal to 8 (bytes) are legal. Any other size sets csr_err and changes no register.
- R4: A write to the invalidate register (index 12) is accepted without error and changes nothing. A read of it returns zero without error.
- R5: A window's compare mask is the inverse of its mask register, limited to bits 30:20. The window matches when the bus address and the window base agree on every bit of that compare mask. All other bus-address bits are ignored for matching.
- R6: Bit 0 of a window base enables the window and bit 1 selects scatter-gather mode. Among enabled matching windows, the lowest index wins. A window that matches but is disabled is skipped.
- R7: When no enabled window matches, the block returns rsp_hit=0 and rsp_addr=0.
- R8: In direct mode, a mask K is built from mask bits 30:20 together with bits 19:0. The result is (translated base AND NOT K) OR (bus address AND K).
- R9: In scatter-gather mode, exactly one memory read is issued, to address (translated base AND NOT(((mask AND 0x7FF00000) >> 10) OR 0x3FF)) OR ((bus address AND ((mask AND 0x7FF00000) OR 0xFE000)) >> 10).
- R10: The scatter-gather result is ((entry AND NOT 1) << 12) OR (bus address bits 12:0).
- R11: Every translated address and page-table-entry address is truncated to its low 34 bits.
- R12: Timing of a request:
    - req_ready is high when the block is idle.
    - A direct or miss result appears with rsp_valid one cycle after the request is accepted.
    - In scatter-gather mode, mem_req_valid is raised the cycle after acceptance and req_ready stays low until the result.
    - The result appears one cycle after mem_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | Register access strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_offset | input | OFF_W | Register byte offset |
| csr_size | input | 4 | Access size in bytes |
| csr_wdata | input | 64 | Write data |
| csr_rsp_valid | output | 1 | Access response strobe |
| csr_rdata | output | 64 | Read data |
| csr_err | output | 1 | Illegal size or unknown register |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | BUS_W | PCI bus address |
| rsp_valid | output | 1 | Translation result strobe |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | DMA_W | Translated address |
| mem_req_valid | output | 1 | Page-table-entry read request |
| mem_req_addr | output | DMA_W | Entry address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |

## Verification
The bench sets up overlapping windows so that a broken priority encoder would pick the catch-all window instead of a lower-indexed one. It then disables a matching window to catch a design that ignores the enable bit. An address with bit 31 set checks that the compare is limited to bits 30:20. A translated base with high bits set, and a page entry with bit 0 and bit 40 set, expose a design that skips the 34-bit truncation or fails to clear the entry's valid bit. During a scatter-gather fetch the bench checks the entry address, that exactly one read is issued, that req_ready stays low, and that the result arrives exactly one cycle after the response. Narrow accesses, unknown indices and invalidate writes are each followed by a read-back, to catch a design that lets them modify a register.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    localparam int          REG_W      = 64;
    localparam int          EN_BIT     = 0;
    localparam int          SG_BIT     = 1;
    localparam logic [63:0] WIN_FIELD  = 64'h0000_0000_7FF0_0000;
    localparam logic [63:0] DIRECT_LOW = 64'h0000_0000_000F_FFFF;
    localparam logic [63:0] SG_PAGE    = 64'h0000_0000_000F_E000;
    localparam logic [63:0] SG_TB_LOW  = 64'h0000_0000_0000_03FF;
    localparam logic [63:0] SG_OFFSET  = 64'h0000_0000_0000_1FFF;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] tbase;
    } win_t;

    // Direct mapping: keep bus bits selected by the mask plus the low 20 bits.
    function automatic logic [63:0] direct_map(input win_t w, input logic [63:0] bus);
        logic [63:0] keep;
        keep = (w.mask & WIN_FIELD) | DIRECT_LOW;
        return (w.tbase & ~keep) | (bus & keep);
    endfunction

    // Address of the page-table entry for a scatter-gather window.
    function automatic logic [63:0] pte_addr(input win_t w, input logic [63:0] bus);
        logic [63:0] tb_keep;
        logic [63:0] bus_keep;
        tb_keep  = ~(((w.mask & WIN_FIELD) >> 10) | SG_TB_LOW);
        bus_keep = (w.mask & WIN_FIELD) | SG_PAGE;
        return (w.tbase & tb_keep) | ((bus & bus_keep) >> 10);
    endfunction

    // Page address from a fetched entry.
    function automatic logic [63:0] sg_map(input logic [63:0] entry, input logic [63:0] bus);
        return ((entry & ~64'h1) << 12) | (bus & SG_OFFSET);
    endfunction

endpackage

// File: rtl/pdx_csr_regs.sv
module pdx_csr_regs
    import pdx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int OFF_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     csr_valid,
    input  logic                     csr_write,
    input  logic [OFF_W-1:0]         csr_offset,
    input  logic [3:0]               csr_size,
    input  logic [REG_W-1:0]         csr_wdata,
    output logic                     csr_rsp_valid,
    output logic [REG_W-1:0]         csr_rdata,
    output logic                     csr_err,
    output win_t [NUM_WIN-1:0]       wins
);

    localparam int IDX_W   = OFF_W - 6;
    localparam int INV_IDX = 3 * NUM_WIN;

    typedef struct packed {
        win_t [NUM_WIN-1:0] win;
        logic [REG_W-1:0]   rdata;
        logic               err;
        logic               rvalid;
    } csr_state_t;

    csr_state_t       st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             found;

    assign idx = IDX_W'(csr_offset >> 6);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = csr_valid;
        st_d.rdata  = '0;
        st_d.err    = 1'b0;
        found       = 1'b0;
        if (csr_valid) begin
            if (csr_size != 4'd8) begin
                st_d.err = 1'b1;
            end else begin
                for (int i = 0; i < NUM_WIN; i++) begin
                    if (idx == IDX_W'(i)) begin
                        found = 1'b1;
                        if (csr_write) st_d.win[i].base = csr_wdata;
                        else           st_d.rdata       = st_q.win[i].base;
                    end
                    if (idx == IDX_W'(NUM_WIN + i)) begin
                        found = 1'b1;
                        if (csr_write) st_d.win[i].mask = csr_wdata;
                        else           st_d.rdata       = st_q.win[i].mask;
                    end
                    if (idx == IDX_W'(2 * NUM_WIN + i)) begin
                        found = 1'b1;
                        if (csr_write) st_d.win[i].tbase = csr_wdata;
                        else           st_d.rdata        = st_q.win[i].tbase;
                    end
                end
                if (idx == IDX_W'(INV_IDX)) found = 1'b1;
                if (!found) st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wins          = st_q.win;
    assign csr_rdata     = st_q.rdata;
    assign csr_err       = st_q.err;
    assign csr_rsp_valid = st_q.rvalid;

    assert_bad_size_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_size != 4'd8) |=> csr_err);

    assert_bad_size_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_write && csr_size != 4'd8) |=> $stable(wins));

    assert_inval_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_size == 4'd8 && idx == IDX_W'(INV_IDX))
        |=> (!csr_err && csr_rdata == '0 && $stable(wins)));

endmodule

// File: rtl/pdx_win_select.sv
module pdx_win_select
    import pdx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int BUS_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  win_t [NUM_WIN-1:0] wins,
    input  logic [BUS_W-1:0]   bus_addr,
    output logic               hit,
    output logic               sel_sg,
    output win_t               sel_win
);

    logic [NUM_WIN-1:0] hit_vec;
    logic [REG_W-1:0]   bus64;

    assign bus64 = REG_W'(bus_addr);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign hit_vec[g] = wins[g].base[EN_BIT] &&
            (((bus64 ^ wins[g].base) & ~wins[g].mask & WIN_FIELD) == '0);
    end

    // Scan from the top down so the lowest index is assigned last.
    always_comb begin
        hit     = 1'b0;
        sel_win = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                sel_win = wins[i];
            end
        end
        sel_sg = hit && sel_win.base[SG_BIT];
    end

    assert_sel_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> sel_win.base[EN_BIT]);

    assert_low_index_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[0] |-> (sel_win == wins[0]));

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
    import pdx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int BUS_W   = 32,
    parameter int DMA_W   = 34,
    parameter int OFF_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_valid,
    input  logic             csr_write,
    input  logic [OFF_W-1:0] csr_offset,
    input  logic [3:0]       csr_size,
    input  logic [63:0]      csr_wdata,
    output logic             csr_rsp_valid,
    output logic [63:0]      csr_rdata,
    output logic             csr_err,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BUS_W-1:0] req_addr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [DMA_W-1:0] rsp_addr,
    output logic             mem_req_valid,
    output logic [DMA_W-1:0] mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data
);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} xl_st_e;

    typedef struct packed {
        xl_st_e           st;
        logic [BUS_W-1:0] bus;
        logic [DMA_W-1:0] pte;
        logic             rvalid;
        logic             rhit;
        logic [DMA_W-1:0] raddr;
    } xl_state_t;

    xl_state_t          xl_d, xl_q;
    win_t [NUM_WIN-1:0] wins;
    win_t               sel_win;
    logic               hit;
    logic               sel_sg;

    pdx_csr_regs #(.NUM_WIN(NUM_WIN), .OFF_W(OFF_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .csr_valid    (csr_valid),
        .csr_write    (csr_write),
        .csr_offset   (csr_offset),
        .csr_size     (csr_size),
        .csr_wdata    (csr_wdata),
        .csr_rsp_valid(csr_rsp_valid),
        .csr_rdata    (csr_rdata),
        .csr_err      (csr_err),
        .wins         (wins)
    );

    pdx_win_select #(.NUM_WIN(NUM_WIN), .BUS_W(BUS_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wins    (wins),
        .bus_addr(req_addr),
        .hit     (hit),
        .sel_sg  (sel_sg),
        .sel_win (sel_win)
    );

    always_comb begin
        xl_d        = xl_q;
        xl_d.rvalid = 1'b0;
        unique case (xl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    xl_d.bus = req_addr;
                    if (sel_sg) begin
                        xl_d.st  = ST_ISSUE;
                        xl_d.pte = DMA_W'(pte_addr(sel_win, REG_W'(req_addr)));
                    end else begin
                        xl_d.rvalid = 1'b1;
                        xl_d.rhit   = hit;
                        xl_d.raddr  = hit ? DMA_W'(direct_map(sel_win, REG_W'(req_addr))) : '0;
                    end
                end
            end
            ST_ISSUE, ST_WAIT: begin
                if (xl_q.st == ST_ISSUE) xl_d.st = ST_WAIT;
                if (mem_rsp_valid) begin
                    xl_d.st     = ST_IDLE;
                    xl_d.rvalid = 1'b1;
                    xl_d.rhit   = 1'b1;
                    xl_d.raddr  = DMA_W'(sg_map(mem_rsp_data, REG_W'(xl_q.bus)));
                end
            end
            default: xl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xl_q <= '{st: ST_IDLE, default: '0};
        else        xl_q <= xl_d;
    end

    assign req_ready     = (xl_q.st == ST_IDLE);
    assign mem_req_valid = (xl_q.st == ST_ISSUE);
    assign mem_req_addr  = xl_q.pte;
    assign rsp_valid     = xl_q.rvalid;
    assign rsp_hit       = xl_q.rhit;
    assign rsp_addr      = xl_q.raddr;

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));

    assert_direct_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !sel_sg) |=> rsp_valid);

    assert_sg_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && sel_sg) |=> (mem_req_valid && !rsp_valid));

    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    assert_sg_finish_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && mem_rsp_valid) |=> (rsp_valid && rsp_hit && req_ready));

endmodule

// File: tb/tb_pci_dma_xlate.sv
`timescale 1ns/1ps
module tb_pci_dma_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0, csr_write = 1'b0;
    logic [11:0] csr_offset = '0;
    logic [3:0]  csr_size = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_rsp_valid, csr_err;
    logic [63:0] csr_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [33:0] rsp_addr;
    logic        mem_req_valid;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    pci_dma_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_offset(csr_offset),
        .csr_size(csr_size), .csr_wdata(csr_wdata), .csr_rsp_valid(csr_rsp_valid),
        .csr_rdata(csr_rdata), .csr_err(csr_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #10 clk = ~clk;

    int     checks = 0;
    int     fails = 0;
    bit     finished = 1'b0;
    longint cyc = 0;
    longint rsp_cyc = 0;
    int     mreq_count = 0;

    logic [63:0] m_base [4];
    logic [63:0] m_mask [4];
    logic [63:0] m_tbase[4];

    always @(posedge clk) cyc <= cyc + 1;

    localparam int NVEC = 9;
    localparam logic [31:0] VEC_ADDR [NVEC] = '{
        32'h0012_3456, 32'h001F_FFFF, 32'h0045_0000, 32'h007F_FFF0, 32'h8045_0000,
        32'h0080_2ABC, 32'h009F_E123, 32'h0020_0000, 32'hFFFF_FFFF };
    localparam int VEC_WIN [NVEC] = '{0, 0, 1, 1, 1, 2, 2, 3, 3};

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ent_of(input logic [33:0] a);
        return ({30'b0, a} << 1) | 64'h1 | (64'h1 << 40);
    endfunction

    function automatic logic [33:0] exp_direct(input int w, input logic [31:0] a);
        logic [63:0] k;
        k = (m_mask[w] & 64'h7FF0_0000) | 64'hF_FFFF;
        return 34'((m_tbase[w] & ~k) | ({32'b0, a} & k));
    endfunction

    function automatic logic [33:0] exp_pte(input int w, input logic [31:0] a);
        logic [63:0] tk, bk;
        tk = ~(((m_mask[w] & 64'h7FF0_0000) >> 10) | 64'h3FF);
        bk = (m_mask[w] & 64'h7FF0_0000) | 64'hF_E000;
        return 34'((m_tbase[w] & tk) | (({32'b0, a} & bk) >> 10));
    endfunction

    function automatic logic [33:0] exp_sg(input int w, input logic [31:0] a);
        logic [63:0] e;
        e = ent_of(exp_pte(w, a));
        return 34'(((e & ~64'h1) << 12) | ({32'b0, a} & 64'h1FFF));
    endfunction

    // Memory responder: answers each entry read three cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [33:0] a;
                mreq_count++;
                a = mem_req_addr;
                repeat (3) @(negedge clk);
                mem_rsp_data  = ent_of(a);
                mem_rsp_valid = 1'b1;
                rsp_cyc       = cyc;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic csr_op(input bit wr, input logic [11:0] off, input logic [3:0] sz,
                          input logic [63:0] wd, output logic [63:0] rd, output logic er);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = wr; csr_offset = off; csr_size = sz; csr_wdata = wd;
        @(negedge clk);
        csr_valid = 1'b0; csr_write = 1'b0;
        rd = csr_rdata;
        er = csr_err;
        check(csr_rsp_valid === 1'b1, "R2 response strobe", 64'(csr_rsp_valid), 64'd1);
    endtask

    task automatic wr_reg(input int idx, input logic [63:0] v);
        logic [63:0] rd;
        logic er;
        csr_op(1'b1, 12'(idx * 64), 4'd8, v, rd, er);
        check(er == 1'b0, "R1 legal write accepted", 64'(er), 64'd0);
        if (idx < 4)       m_base[idx]    = v;
        else if (idx < 8)  m_mask[idx-4]  = v;
        else if (idx < 12) m_tbase[idx-8] = v;
    endtask

    task automatic rd_expect(input logic [11:0] off, input logic [63:0] exp, input bit exp_err, input string tag);
        logic [63:0] rd;
        logic er;
        csr_op(1'b0, off, 4'd8, 64'd0, rd, er);
        check(rd == exp && er == exp_err, tag, rd, exp);
    endtask

    function automatic logic [63:0] model_reg(input int idx);
        if (idx < 4)  return m_base[idx];
        if (idx < 8)  return m_mask[idx-4];
        return m_tbase[idx-8];
    endfunction

    task automatic do_xlate(input logic [31:0] a, input int w, input string tag);
        bit          sg;
        logic [33:0] exp;
        int          n0;
        bit          busy_ok;
        sg = (w >= 0) && m_base[w][1];
        n0 = mreq_count;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        check(req_ready === 1'b1, "R12 ready while idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (!sg) begin
            exp = (w < 0) ? 34'd0 : exp_direct(w, a);
            check(rsp_valid === 1'b1 && rsp_hit === (w >= 0) && rsp_addr === exp,
                  tag, 64'(rsp_addr), 64'(exp));
        end else begin
            check(mem_req_valid === 1'b1 && mem_req_addr === exp_pte(w, a),
                  "R9 entry address", 64'(mem_req_addr), 64'(exp_pte(w, a)));
            check(rsp_valid === 1'b0, "R12 no early result", 64'(rsp_valid), 64'd0);
            busy_ok = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                #1;
                if (rsp_valid) break;
                if (req_ready) busy_ok = 1'b0;
            end
            check(busy_ok, "R12 ready low during fetch", 64'(busy_ok), 64'd1);
            exp = exp_sg(w, a);
            check(rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_addr === exp,
                  tag, 64'(rsp_addr), 64'(exp));
            check(cyc == rsp_cyc + 1, "R12 result one cycle after response",
                  64'(cyc), 64'(rsp_cyc + 1));
            check(mreq_count == n0 + 1, "R9 single entry read", 64'(mreq_count), 64'(n0 + 1));
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_tbase[i] = '0;
        end
    endtask

    task automatic configure();
        wr_reg(0,  64'h0000_0000_0010_0001);
        wr_reg(4,  64'h0000_0000_0000_0000);
        wr_reg(8,  64'hF000_0003_1230_0000);
        wr_reg(1,  64'h0000_0000_0040_0001);
        wr_reg(5,  64'h0000_0000_0030_0000);
        wr_reg(9,  64'h0000_0001_8000_0000);
        wr_reg(2,  64'h0000_0000_0080_0003);
        wr_reg(6,  64'h0000_0000_0010_0000);
        wr_reg(10, 64'h0000_0000_0012_0000);
        wr_reg(3,  64'h0000_0000_0000_0001);
        wr_reg(7,  64'h0000_0000_7FF0_0000);
        wr_reg(11, 64'h0000_0002_0000_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic        er;
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
              "R1 reset outputs", {61'b0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        for (int i = 0; i < 12; i++) rd_expect(12'(i * 64), 64'd0, 1'b0, "R1 register zero after reset");
        do_xlate(32'h0012_3456, -1, "R7 miss with all windows disabled");

        // R1/R2 write and read back
        configure();
        for (int i = 0; i < 12; i++) rd_expect(12'(i * 64), model_reg(i), 1'b0, "R1 R2 register readback");

        // Vector table: R5, R6, R8, R10, R11
        for (int v = 0; v < NVEC; v++) begin
            do_xlate(VEC_ADDR[v], VEC_WIN[v], $sformatf("R5 R6 R8 R10 R11 vector %0d", v));
        end

        // R2 low offset bits ignored
        rd_expect(12'h07C, m_base[1], 1'b0, "R2 low offset bits ignored");
        csr_op(1'b1, 12'h0A5, 4'd8, 64'h0000_0000_0030_0000, rd, er); // index 2 -> mask of window 2? index 2 is base 2
        m_base[2] = 64'h0000_0000_0030_0000;
        check(er == 1'b0, "R2 write with low bits set", 64'(er), 64'd0);
        rd_expect(12'h080, m_base[2], 1'b0, "R2 write landed on index 2");
        wr_reg(2, 64'h0000_0000_0080_0003);

        // R2 unknown index
        rd_expect(12'h340, 64'd0, 1'b1, "R2 unknown index read");
        csr_op(1'b1, 12'hFC0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, rd, er);
        check(er == 1'b1, "R2 unknown index write flagged", 64'(er), 64'd1);
        for (int i = 0; i < 12; i++) rd_expect(12'(i * 64), model_reg(i), 1'b0, "R2 unknown write had no effect");

        // R3 narrow accesses
        csr_op(1'b1, 12'h200, 4'd4, 64'h1234_5678_9ABC_DEF0, rd, er);
        check(er == 1'b1, "R3 narrow write flagged", 64'(er), 64'd1);
        rd_expect(12'h200, m_tbase[0], 1'b0, "R3 narrow write changed nothing");
        csr_op(1'b0, 12'h000, 4'd1, 64'd0, rd, er);
        check(er == 1'b1, "R3 narrow read flagged", 64'(er), 64'd1);

        // R4 invalidate register
        csr_op(1'b1, 12'h300, 4'd8, 64'hDEAD_BEEF_0000_0001, rd, er);
        check(er == 1'b0, "R4 invalidate write accepted", 64'(er), 64'd0);
        rd_expect(12'h300, 64'd0, 1'b0, "R4 invalidate reads zero");
        do_xlate(VEC_ADDR[0], 0, "R4 translation unchanged after invalidate");
        do_xlate(VEC_ADDR[5], 2, "R4 scatter-gather unchanged after invalidate");

        // R6 matching but disabled window is skipped
        wr_reg(0, 64'h0000_0000_0010_0000);
        do_xlate(32'h0012_3456, 3, "R6 disabled window falls through");

        // R7 miss once the catch-all is disabled
        wr_reg(3, 64'h0000_0000_0000_0000);
        do_xlate(32'h0020_0000, -1, "R7 miss gives zero");
        do_xlate(32'h8000_0000, -1, "R7 miss with high bit set");

        // R1 reset clears registers again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        rd_expect(12'h040, 64'd0, 1'b0, "R1 reset clears window base");
        rd_expect(12'h280, 64'd0, 1'b0, "R1 reset clears translated base");
        do_xlate(32'h0045_0000, -1, "R1 windows disabled after reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule